// File: doc/BRIEF.md
# Task-Mapped Memory Management Unit

This block sits between an 8-bit CPU with a 16-bit logical address space and a system bus with 24-bit physical addresses. An 8-bit task register picks the translation. Its low nibble selects one of sixteen page tables held in a 512-byte map RAM. Its high nibble is copied straight into the top four bits of every physical address. Each 4 KB logical page is relocated through one map entry, and the 12-bit offset passes through unchanged.

While the low task nibble is zero, the first 4 KB of logical memory is a private local window instead of bus memory. The window holds 1 KB of scratch RAM, four byte-wide register ports, a write-only view of the map RAM and a 1 KB monitor ROM window. The ROM itself sits outside the block. Local locations that decode to nothing read as 0xFF, ignore writes and raise a one-cycle unmapped pulse. For I/O cycles no translation takes place. When bit 7 of the mask register is set, the 8-bit port number is copied onto the high byte of the 16-bit I/O address.

Every access is sampled on a rising clock edge with `rd` or `wr` held high for that one cycle. All results are presented after that same edge.

Top module: `task_mmu`

## Requirements
- R1: After a synchronous reset, the task and mask registers read 0, and `ext_sel`, `local_sel`, `unmapped`, `disp_seg_wr` and `disp_col_wr` are 0. The CPU therefore starts in task 0 with the local window visible.
- R2: A memory access outside the local window drives `ext_sel`=1. `phys_addr` is then {task[7:4], map entry, logical address[11:0]}, with the map entry in bits 19:12.
- R3: The map entry used is the one at index {task[3:0], logical address[15:12], 0}. Odd map locations never take part in translation.
- R4: A memory access with task[3:0]=0 and a logical address below 0x1000 is local: `local_sel`=1 and `ext_sel`=0, whatever task[7:4] holds.
- R5: Local addresses 0x000–0x3FF reach a 1 KB scratch RAM indexed by address bits 9:0. A read returns the byte last written there.
- R6: Local reads of 0x400, 0x401, 0x402 and 0x403 return `trap_addr_in`, `keypad_in`, `switch_in` and `trap_stat_in` respectively.
- R7: Local writes act as follows:
  - 0x400 pulses `disp_seg_wr` for one cycle, with the byte on `disp_wdata`.
  - 0x401 pulses `disp_col_wr` in the same way.
  - 0x402 loads the task register.
  - 0x403 loads the mask register.
  - Both registers are visible on `task_q` and `mask_q`, and a new task value applies from the next access on.
- R8: A local write to 0x600–0x7FF stores the byte in the map RAM at index (address − 0x600).
- R9: A local read of 0x800–0xBFF drives `rom_addr` = {`trap_reset`, address[9:0]} and returns `rom_rdata`.
- R10: An I/O access drives `ext_sel`=1 and `phys_addr` = {8'h00, high byte, port}. The high byte is the port number when mask bit 7 is 1, and logical address[15:8] otherwise.
- R11: The remaining local locations are treated as unmapped: 0x404–0x5FF, 0xC00–0xFFF, reads of 0x600–0x7FF and writes of 0x800–0xBFF. On such an access `unmapped` pulses for one cycle and a read returns 0xFF. A write changes no register and fires no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Logical memory address or I/O port address |
| cpu_wdata | input | 8 | Write data |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| trap_reset | input | 1 | Selects the upper 1 KB half of the monitor ROM |
| trap_addr_in | input | 8 | Value returned at local 0x400 |
| keypad_in | input | 8 | Value returned at local 0x401 |
| switch_in | input | 8 | Value returned at local 0x402 |
| trap_stat_in | input | 8 | Value returned at local 0x403 |
| rom_rdata | input | 8 | Data from the external monitor ROM |
| rom_addr | output | 11 | Monitor ROM address, combinational from the current access |
| phys_addr | output | 24 | Translated physical address or I/O address |
| ext_sel | output | 1 | The sampled access goes to the external bus |
| local_sel | output | 1 | The sampled access hit the local window |
| local_rdata | output | 8 | Read data from the local window |
| unmapped | output | 1 | One-cycle pulse for an undecoded local access |
| disp_seg_wr | output | 1 | Display segment latch strobe |
| disp_col_wr | output | 1 | Display column latch strobe |
| disp_wdata | output | 8 | Data for the display latches |
| task_q | output | 8 | Current task register |
| mask_q | output | 8 | Current mask register |

## Verification
Every result has a latency of one cycle. The translated address, the select lines, the unmapped pulse, the display strobes and the local read data are all valid just after the rising edge that samples the access. A task or mask write takes effect on the access that follows. The bench drives each access on a falling edge and waits for the next rising edge. It then samples 1 ns later, so each check reads the value produced by exactly that access. Translation vectors first program the task through a local write and then issue the access one cycle later, so the new task is already in force when that access is sampled.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_SCRATCH,
    HIT_REG,
    HIT_MAP,
    HIT_ROM,
    HIT_UNMAPPED
  } hit_e;
endpackage

// File: rtl/mmu_sdp_ram.sv
module mmu_sdp_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mmu_local_decode.sv
module mmu_local_decode
  import mmu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              task_zero,
  input  logic              is_io,
  input  logic              rd,
  input  logic              wr,
  output hit_e              hit
);
  logic [WIN_W-1:0] off;
  assign off = addr[WIN_W-1:0];

  always_comb begin
    hit = HIT_NONE;
    if ((rd || wr) && !is_io && task_zero && (addr[ADDR_W-1:WIN_W] == '0)) begin
      if (off[11:10] == 2'b00)           hit = HIT_SCRATCH;
      else if (off[11:2] == 10'h100)     hit = HIT_REG;
      else if (off[11:9] == 3'b011 && wr) hit = HIT_MAP;
      else if (off[11:10] == 2'b10 && rd) hit = HIT_ROM;
      else                               hit = HIT_UNMAPPED;
    end
  end
endmodule

// File: rtl/task_mmu.sv
module task_mmu
  import mmu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TASK_W = 8,
  parameter int PHYS_W = 24,
  parameter int OFF_W  = 12,
  parameter int SCR_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              rd,
  input  logic              wr,
  input  logic              is_io,
  input  logic              trap_reset,
  input  logic [DATA_W-1:0] trap_addr_in,
  input  logic [DATA_W-1:0] keypad_in,
  input  logic [DATA_W-1:0] switch_in,
  input  logic [DATA_W-1:0] trap_stat_in,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [SCR_AW:0]   rom_addr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              ext_sel,
  output logic              local_sel,
  output logic [DATA_W-1:0] local_rdata,
  output logic              unmapped,
  output logic              disp_seg_wr,
  output logic              disp_col_wr,
  output logic [DATA_W-1:0] disp_wdata,
  output logic [TASK_W-1:0] task_q,
  output logic [DATA_W-1:0] mask_q
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int SEL_W  = TASK_W / 2;
  localparam int MAP_AW = SEL_W + PAGE_W + 1;
  localparam int TOP_W  = PHYS_W - DATA_W - OFF_W;
  localparam int IO_PAD = PHYS_W - ADDR_W;
  localparam int HB     = ADDR_W - DATA_W;

  hit_e hit;
  logic task_zero;
  assign task_zero = (task_q[SEL_W-1:0] == '0);

  mmu_local_decode #(.ADDR_W(ADDR_W), .WIN_W(OFF_W)) u_dec (
    .addr(cpu_addr), .task_zero(task_zero), .is_io(is_io),
    .rd(rd), .wr(wr), .hit(hit)
  );

  // page table: index {task[3:0], page, 0}
  logic [MAP_AW-1:0] map_ridx;
  logic [DATA_W-1:0] map_entry;
  assign map_ridx = {task_q[SEL_W-1:0], cpu_addr[ADDR_W-1:OFF_W], 1'b0};

  mmu_sdp_ram #(.AW(MAP_AW), .DW(DATA_W)) u_map (
    .clk(clk), .we(hit == HIT_MAP), .waddr(cpu_addr[MAP_AW-1:0]),
    .wdata(cpu_wdata), .raddr(map_ridx), .rdata(map_entry)
  );

  logic [DATA_W-1:0] scr_dout;
  mmu_sdp_ram #(.AW(SCR_AW), .DW(DATA_W)) u_scr (
    .clk(clk), .we(hit == HIT_SCRATCH && wr), .waddr(cpu_addr[SCR_AW-1:0]),
    .wdata(cpu_wdata), .raddr(cpu_addr[SCR_AW-1:0]), .rdata(scr_dout)
  );

  assign rom_addr = {trap_reset, cpu_addr[SCR_AW-1:0]};

  logic [DATA_W-1:0] reg_rd;
  always_comb begin
    case (cpu_addr[1:0])
      2'd0:    reg_rd = trap_addr_in;
      2'd1:    reg_rd = keypad_in;
      2'd2:    reg_rd = switch_in;
      default: reg_rd = trap_stat_in;
    endcase
  end

  logic              io_q;
  logic [ADDR_W-1:0] io_addr_q;
  logic [TOP_W-1:0]  top_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] rdata_q;
  logic              scr_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      task_q      <= '0;
      mask_q      <= '0;
      ext_sel     <= 1'b0;
      local_sel   <= 1'b0;
      unmapped    <= 1'b0;
      disp_seg_wr <= 1'b0;
      disp_col_wr <= 1'b0;
      disp_wdata  <= '0;
      io_q        <= 1'b0;
      io_addr_q   <= '0;
      top_q       <= '0;
      off_q       <= '0;
      rdata_q     <= '1;
      scr_sel_q   <= 1'b0;
    end else begin
      ext_sel     <= (rd || wr) && (hit == HIT_NONE);
      local_sel   <= (hit != HIT_NONE);
      unmapped    <= (hit == HIT_UNMAPPED);
      disp_seg_wr <= 1'b0;
      disp_col_wr <= 1'b0;
      io_q        <= is_io;
      io_addr_q   <= {(mask_q[DATA_W-1] ? cpu_addr[DATA_W-1:0] : cpu_addr[ADDR_W-1:HB]),
                      cpu_addr[DATA_W-1:0]};
      top_q       <= task_q[TASK_W-1:SEL_W];
      off_q       <= cpu_addr[OFF_W-1:0];
      rdata_q     <= '1;
      scr_sel_q   <= (hit == HIT_SCRATCH) && rd;
      if (hit == HIT_REG && rd) rdata_q <= reg_rd;
      if (hit == HIT_ROM)       rdata_q <= rom_rdata;
      if (hit == HIT_REG && wr) begin
        disp_wdata <= cpu_wdata;
        case (cpu_addr[1:0])
          2'd0:    disp_seg_wr <= 1'b1;
          2'd1:    disp_col_wr <= 1'b1;
          2'd2:    task_q      <= cpu_wdata;
          default: mask_q      <= cpu_wdata;
        endcase
      end
    end
  end

  assign local_rdata = scr_sel_q ? scr_dout : rdata_q;
  assign phys_addr   = io_q ? {{IO_PAD{1'b0}}, io_addr_q} : {top_q, map_entry, off_q};
endmodule

// File: rtl/mmu_checker.sv
module mmu_checker (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cpu_addr,
  input logic        rd,
  input logic        wr,
  input logic        is_io,
  input logic        ext_sel,
  input logic        local_sel,
  input logic [7:0]  local_rdata,
  input logic        unmapped,
  input logic        disp_seg_wr,
  input logic        disp_col_wr,
  input logic [7:0]  task_q,
  input logic [7:0]  mask_q
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (task_q == 8'h00 && mask_q == 8'h00 && !ext_sel && !local_sel));

  assert_one_target_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({local_sel, ext_sel}));

  assert_seg_origin_R7: assert property (@(posedge clk) disable iff (rst)
    disp_seg_wr |-> $past(wr && !is_io && cpu_addr == 16'h0400 && task_q[3:0] == 4'h0));

  assert_task_origin_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(task_q)) |->
      $past(wr && !is_io && cpu_addr == 16'h0402 && task_q[3:0] == 4'h0));

  assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> (local_sel && !ext_sel && !disp_seg_wr && !disp_col_wr));

  assert_unmapped_ff_R11: assert property (@(posedge clk) disable iff (rst)
    (unmapped && $past(rd)) |-> local_rdata == 8'hFF);
endmodule

bind task_mmu mmu_checker u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .rd(rd), .wr(wr), .is_io(is_io),
  .ext_sel(ext_sel), .local_sel(local_sel), .local_rdata(local_rdata),
  .unmapped(unmapped), .disp_seg_wr(disp_seg_wr), .disp_col_wr(disp_col_wr),
  .task_q(task_q), .mask_q(mask_q)
);

// File: tb/tb_task_mmu.sv
module tb_task_mmu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        rd = 1'b0, wr = 1'b0, is_io = 1'b0, trap_reset = 1'b0;
  logic [7:0]  rom_rdata;
  logic [10:0] rom_addr;
  logic [23:0] phys_addr;
  logic        ext_sel, local_sel, unmapped, disp_seg_wr, disp_col_wr;
  logic [7:0]  local_rdata, disp_wdata, task_q, mask_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  assign rom_rdata = rom_addr[10] ? ~rom_addr[7:0] : rom_addr[7:0];

  task_mmu dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rd(rd), .wr(wr), .is_io(is_io), .trap_reset(trap_reset),
    .trap_addr_in(8'hA1), .keypad_in(8'hB2), .switch_in(8'hC3),
    .trap_stat_in(8'hD4), .rom_rdata(rom_rdata), .rom_addr(rom_addr),
    .phys_addr(phys_addr), .ext_sel(ext_sel), .local_sel(local_sel),
    .local_rdata(local_rdata), .unmapped(unmapped), .disp_seg_wr(disp_seg_wr),
    .disp_col_wr(disp_col_wr), .disp_wdata(disp_wdata), .task_q(task_q),
    .mask_q(mask_q)
  );

  // {task, logical address, expected physical address}
  localparam logic [47:0] VEC [6] = '{
    {8'h01, 16'h0123, 24'h0A5123},
    {8'h91, 16'hF456, 24'h93C456},
    {8'h43, 16'h7FFF, 24'h481FFF},
    {8'hFF, 16'hFABC, 24'hF7EABC},
    {8'h20, 16'h5001, 24'h212001},
    {8'h02, 16'h9ABC, 24'h05AABC}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic io, input logic w, input logic r,
                        input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    is_io = io; wr = w; rd = r; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; is_io = 1'b0; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    do_reset();
    #1;
    check("R1 task", task_q, 8'h00);
    check("R1 mask", mask_q, 8'h00);
    check("R1 ext_sel", ext_sel, 1'b0);
    check("R1 local_sel", local_sel, 1'b0);
    check("R1 unmapped", unmapped, 1'b0);

    // R8: program page tables through the local window
    access(0, 1, 0, 16'h0620, 8'hA5);
    access(0, 1, 0, 16'h063E, 8'h3C);
    access(0, 1, 0, 16'h066E, 8'h81);
    access(0, 1, 0, 16'h07FE, 8'h7E);
    access(0, 1, 0, 16'h060A, 8'h12);
    access(0, 1, 0, 16'h0652, 8'h5A);
    access(0, 1, 0, 16'h0621, 8'hEE); // odd byte, unused by R3
    check("R8 map write local", local_sel, 1'b1);

    // R5 scratch
    access(0, 1, 0, 16'h0000, 8'h11);
    access(0, 1, 0, 16'h03FF, 8'h22);
    access(0, 0, 1, 16'h03FF, 8'h00);
    check("R5 scratch 3FF", local_rdata, 8'h22);
    access(0, 0, 1, 16'h0000, 8'h00);
    check("R5 scratch 000", local_rdata, 8'h11);

    // R6 register reads
    access(0, 0, 1, 16'h0400, 8'h00); check("R6 trap addr", local_rdata, 8'hA1);
    check("R4 local not ext", ext_sel, 1'b0);
    access(0, 0, 1, 16'h0401, 8'h00); check("R6 keypad", local_rdata, 8'hB2);
    access(0, 0, 1, 16'h0402, 8'h00); check("R6 switch", local_rdata, 8'hC3);
    access(0, 0, 1, 16'h0403, 8'h00); check("R6 status", local_rdata, 8'hD4);

    // R7 display writes
    access(0, 1, 0, 16'h0400, 8'h5A);
    check("R7 seg strobe", {disp_seg_wr, disp_col_wr}, 2'b10);
    check("R7 seg data", disp_wdata, 8'h5A);
    access(0, 1, 0, 16'h0401, 8'h3C);
    check("R7 col strobe", {disp_seg_wr, disp_col_wr}, 2'b01);
    check("R7 col data", disp_wdata, 8'h3C);

    // R9 ROM window
    trap_reset = 1'b0;
    access(0, 0, 1, 16'h0805, 8'h00);
    check("R9 rom lo", local_rdata, 8'h05);
    trap_reset = 1'b1;
    access(0, 0, 1, 16'h0BF0, 8'h00);
    check("R9 rom hi", local_rdata, 8'h0F);
    trap_reset = 1'b0;

    // R11 unmapped
    access(0, 0, 1, 16'h0500, 8'h00);
    check("R11 read ff", local_rdata, 8'hFF);
    check("R11 pulse", unmapped, 1'b1);
    access(0, 1, 0, 16'h0404, 8'h07);
    check("R11 write pulse", unmapped, 1'b1);
    check("R11 no strobe", {disp_seg_wr, disp_col_wr}, 2'b00);
    check("R11 task kept", task_q, 8'h00);
    access(0, 0, 1, 16'h0600, 8'h00);
    check("R11 map read ff", local_rdata, 8'hFF);
    access(0, 0, 1, 16'h0C00, 8'h00);
    check("R11 c00 ff", local_rdata, 8'hFF);
    check("R11 single pulse", unmapped, 1'b1);
    access(0, 0, 1, 16'h0402, 8'h00);
    check("R11 pulse ends", unmapped, 1'b0);

    // R10 I/O mirroring
    access(0, 1, 0, 16'h0403, 8'h80);
    check("R7 mask write", mask_q, 8'h80);
    access(1, 0, 1, 16'h1234, 8'h00);
    check("R10 mirror", phys_addr, 24'h003434);
    check("R10 ext", ext_sel, 1'b1);
    access(0, 1, 0, 16'h0403, 8'h00);
    access(1, 1, 0, 16'h1234, 8'h55);
    check("R10 no mirror", phys_addr, 24'h001234);

    // R4 upper task nibble keeps local window
    access(0, 1, 0, 16'h0402, 8'h20);
    check("R7 task write", task_q, 8'h20);
    access(0, 0, 1, 16'h0402, 8'h00);
    check("R4 local sel", {local_sel, ext_sel}, 2'b10);
    check("R4 local data", local_rdata, 8'hC3);

    // R2/R3 translation vectors
    for (int i = 0; i < 6; i++) begin
      do_reset();
      access(0, 1, 0, 16'h0402, VEC[i][47:40]);
      access(0, 0, 1, VEC[i][39:24], 8'h00);
      check("R2 R3 phys", phys_addr, VEC[i][23:0]);
      check("R2 ext_sel", {ext_sel, local_sel}, 2'b10);
    end

    // R4: nonzero low task nibble sends low page to the bus
    access(0, 0, 1, 16'h0402, 8'h00);
    check("R4 task nonzero goes ext", {ext_sel, local_sel}, 2'b10);

    done = 1'b1;
    finish_run();
  end
endmodule